// File: doc/BRIEF.md
# Compare Timer with Periodic Reload

This block is a 64-bit free-running tick counter paired with a 64-bit comparator and a sticky event flag that can raise an interrupt line. A host reaches it through a small 32-bit register bus. Each write takes effect at the clock edge that captures it. Each read returns its word one cycle after the read strobe. Because the count and the comparator are wider than the bus, each one is held in two word registers, a low half and a high half.

For a single deadline, software loads the comparator and enables counting and comparison. When the count reaches or passes the comparator, the event flag is set. For a steady tick, software also programs a step value and enables automatic reload. Every event then moves the comparator forward by the step, so the interrupt repeats at a fixed period and software only has to acknowledge the flag.

A host reads a coherent 64-bit count in three steps. It reads the high half, then the low half, then the high half again, and retries if the two high reads differ. This works because the carry into the high half lands on the same clock edge on which the low half wraps.

Top module: `cmp_timer64`

## Requirements
- R1: After a synchronous reset, every register reads 0: count, control, event flag, comparator and step. The interrupt output is low.
- R2: The register offsets are fixed. 0x00 holds the count low word and 0x04 the count high word. 0x08 is control and 0x0C is status. 0x10 holds the comparator low word and 0x14 the comparator high word. 0x18 is the reload step. A read strobed in cycle n returns, after the edge that ends cycle n, the register value as it stood during cycle n.
- R3: While control bit 0 (run) is 1, the count rises by one on every clock edge. The carry from the low word enters the high word on the same edge on which the low word wraps from 0xFFFFFFFF to 0.
- R4: A write to either count half loads that half only while run is 0. Writes to the count halves while run is 1 are dropped.
- R5: Control bit 1 enables comparison. A compare event occurs in a cycle where run and compare are both 1 and the count is greater than or equal to the comparator. The flag (status bit 0) is 1 after the edge that ends that cycle.
- R6: Each comparator value produces at most one event. Writing either comparator half arms it again.
- R7: When an event occurs while control bit 3 (auto-reload) is 1, the comparator is increased by the step at the same edge. A nonzero step keeps the comparator armed, so events repeat at a fixed period.
- R8: Writing status with bit 0 set clears the flag, and writing it with bit 0 clear leaves the flag unchanged. If an event and a clearing write happen in the same cycle, the flag ends up set.
- R9: The interrupt output is high exactly while the flag is 1 and control bit 2 (interrupt enable) is 1.
- R10: Reads of any other offset, including unaligned ones, return 0, and writes to them change nothing. Control bits 31:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the host drives the bus synchronously. They also assume the host never strobes a read and a write in the same cycle, and never writes a comparator half in the same cycle as an event it wants reloaded. The stimulus keeps within these limits. Every access is issued between clock edges, one operation per cycle. Random data goes only into the comparator, step and unmapped offsets while the counter is stopped. The timed corner cases are exact deadlines, the clear that meets an event, the low-word wrap and periodic reload. They are driven as directed sequences whose edge counts are worked out beforehand.

// File: rtl/ct_pkg.sv
package ct_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 2 * WORD_W;
  localparam int NREG   = 7;

  // register index; byte offset = index * 4
  localparam int IX_CNT_LO = 0;
  localparam int IX_CNT_HI = 1;
  localparam int IX_CTRL   = 2;
  localparam int IX_STAT   = 3;
  localparam int IX_CMP_LO = 4;
  localparam int IX_CMP_HI = 5;
  localparam int IX_STEP   = 6;

  // bit 3 autoreload, bit 2 irq enable, bit 1 compare enable, bit 0 run
  typedef struct packed {
    logic reload;
    logic irq_en;
    logic cmp_en;
    logic run;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] put_half(input logic [CNT_W-1:0] cur,
                                                input logic [WORD_W-1:0] w,
                                                input logic upper);
    logic [CNT_W-1:0] r;
    r = cur;
    if (upper) r[CNT_W-1:WORD_W] = w;
    else       r[WORD_W-1:0]     = w;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] base,
                                               input logic [WORD_W-1:0] step);
    return base + {{(CNT_W-WORD_W){1'b0}}, step};
  endfunction

  function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] cmp);
    return cnt >= cmp;
  endfunction

endpackage

// File: rtl/ct_counter.sv
module ct_counter
  import ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);

  logic load_ok;
  assign load_ok = !run && (ld_lo || ld_hi);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
    else if (load_ok) cnt <= put_half(cnt, wdata, ld_hi);
  end

  p_tick_carry_r3: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt == $past(cnt) + 1'b1);

  p_locked_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (run && ld_hi) |=> cnt[CNT_W-1:WORD_W] == $past(cnt[CNT_W-1:WORD_W])
                     || $past(cnt[WORD_W-1:0]) == '1);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt));

endmodule

// File: rtl/ct_compare.sv
module ct_compare
  import ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  ctrl_t             ctrl,
  input  logic [WORD_W-1:0] step,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr_req,
  output logic [CNT_W-1:0]  cmp,
  output logic              flag,
  output logic              hit
);

  logic armed;
  logic keep_armed;

  assign hit        = ctrl.run && ctrl.cmp_en && armed && reached(cnt, cmp);
  assign keep_armed = ctrl.reload && (step != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp   <= '0;
      armed <= 1'b1;
    end else if (ld_lo || ld_hi) begin
      cmp   <= put_half(cmp, wdata, ld_hi);
      armed <= 1'b1;
    end else if (hit) begin
      if (ctrl.reload) cmp <= advance(cmp, step);
      armed <= keep_armed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  p_event_flag_r5: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && ctrl.reload && !ld_lo && !ld_hi) |=> cmp == $past(cmp) + $past(step));

  p_single_fire_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && !keep_armed && !ld_lo && !ld_hi) |=> !hit);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !hit) |=> !flag);

  p_no_spont_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (!flag && !hit) |=> !flag);

endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [WORD_W-1:0] step,
  output logic [NREG-1:0]   wsel
);

  localparam int CTRL_W = $bits(ctrl_t);

  logic [NREG-1:0]   asel;
  logic              mapped;
  logic [WORD_W-1:0] view [NREG];
  logic [WORD_W-1:0] rd_next;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign asel[i] = (bus_addr == ADDR_W'(i * 4));
    assign wsel[i] = bus_wr && asel[i];
  end

  assign mapped = |asel;

  assign view[IX_CNT_LO] = cnt[WORD_W-1:0];
  assign view[IX_CNT_HI] = cnt[CNT_W-1:WORD_W];
  assign view[IX_CTRL]   = {{(WORD_W-CTRL_W){1'b0}}, ctrl};
  assign view[IX_STAT]   = {{(WORD_W-1){1'b0}}, flag};
  assign view[IX_CMP_LO] = cmp[WORD_W-1:0];
  assign view[IX_CMP_HI] = cmp[CNT_W-1:WORD_W];
  assign view[IX_STEP]   = step;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NREG; i++)
      if (asel[i]) rd_next = view[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      step      <= '0;
      bus_rdata <= '0;
    end else begin
      if (wsel[IX_CTRL]) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wsel[IX_STEP]) step <= bus_wdata;
      if (bus_rd)        bus_rdata <= rd_next;
    end
  end

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> bus_rdata == '0);

  p_ctrl_upper_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && asel[IX_CTRL]) |=> bus_rdata[WORD_W-1:CTRL_W] == '0);

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wsel[IX_CTRL] |=> $stable(ctrl));

endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
  import ct_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  ctrl_t             ctrl;
  logic [WORD_W-1:0] step;
  logic [NREG-1:0]   wsel;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic              flag;
  logic              hit;
  logic              clr_req;

  assign clr_req = wsel[IX_STAT] && bus_wdata[0];

  ct_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cnt(cnt), .cmp(cmp), .flag(flag), .ctrl(ctrl), .step(step), .wsel(wsel)
  );

  ct_counter u_counter (
    .clk(clk), .rst(rst), .run(ctrl.run), .ld_lo(wsel[IX_CNT_LO]),
    .ld_hi(wsel[IX_CNT_HI]), .wdata(bus_wdata), .cnt(cnt)
  );

  ct_compare u_compare (
    .clk(clk), .rst(rst), .cnt(cnt), .ctrl(ctrl), .step(step),
    .ld_lo(wsel[IX_CMP_LO]), .ld_hi(wsel[IX_CMP_HI]), .wdata(bus_wdata),
    .clr_req(clr_req), .cmp(cmp), .flag(flag), .hit(hit)
  );

  assign irq = flag && ctrl.irq_en;

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(hit) || $past(wsel[IX_CTRL])));

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(clr_req) || $past(wsel[IX_CTRL])));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && cnt == '0 && cmp == '0));

endmodule

// File: tb/cmp_timer64_tb.sv
module cmp_timer64_tb;

  localparam logic [7:0] A_CLO = 8'h00, A_CHI = 8'h04, A_CTL = 8'h08,
                         A_STA = 8'h0C, A_PLO = 8'h10, A_PHI = 8'h14,
                         A_STP = 8'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  cmp_timer64 u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [63:0] after_ticks(input logic [63:0] s, input int k);
    return s + 64'(k);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  task automatic load_cnt(input logic [63:0] v);
    wr(A_CLO, v[31:0]);
    wr(A_CHI, v[63:32]);
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(A_CLO, lo);
    rd(A_CHI, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, h1, lo, h2;
    logic [63:0] v, s;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    rd(A_CLO, d); chk("R1 cnt lo", d, 0);
    rd(A_CHI, d); chk("R1 cnt hi", d, 0);
    rd(A_CTL, d); chk("R1 ctrl", d, 0);
    rd(A_STA, d); chk("R1 flag", d, 0);
    rd(A_PLO, d); chk("R1 cmp lo", d, 0);
    rd(A_PHI, d); chk("R1 cmp hi", d, 0);
    rd(A_STP, d); chk("R1 step", d, 0);
    chk("R1 irq", irq, 0);

    // R2, R10: random register traffic while stopped
    for (int i = 0; i < 24; i++) begin
      logic [31:0] r = $urandom;
      logic [7:0] a;
      case ($urandom_range(0, 2))
        0: a = A_PLO;
        1: a = A_PHI;
        default: a = A_STP;
      endcase
      wr(a, r);
      rd(a, d); chk("R2 readback", d, r);
      a = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(7, 63) * 4)
                                      : 8'($urandom_range(0, 63) * 4 + 1);
      wr(a, ~r);
      rd(a, d); chk("R10 unmapped read", d, 0);
      rd(A_CTL, d); chk("R10 unmapped write ignored", d, 0);
    end
    wr(A_CTL, 32'hFFFF_FFF0);
    rd(A_CTL, d); chk("R10 ctrl upper bits", d, 0);

    // R3: random run lengths
    for (int i = 0; i < 4; i++) begin
      int k = $urandom_range(1, 40);
      s = {$urandom, 32'hFFFF_FFFF - 32'($urandom_range(0, 30))};
      load_cnt(s);
      wr(A_CTL, 32'h1);
      idle(k);
      wr(A_CTL, 32'h0);
      rd_cnt(v); chk("R3 run length", v, after_ticks(s, k + 1));
    end

    // R3: coherent high/low/high read across the low wrap
    s = {32'd7, 32'hFFFF_FFFE};
    load_cnt(s);
    wr(A_CTL, 32'h1);
    rd(A_CHI, h1); rd(A_CLO, lo); rd(A_CHI, h2);
    chk("R3 first high", h1, 7);
    chk("R3 second high after carry", h2, 8);
    rd(A_CHI, h1); rd(A_CLO, lo); rd(A_CHI, h2);
    chk("R3 retry coherent", {h2, lo}, {32'd8, 32'd2});
    chk("R3 retry highs agree", h1, h2);
    wr(A_CTL, 32'h0);
    rd_cnt(v); chk("R3 after stop", v, after_ticks(s, 7));

    // R4: count write while running is dropped
    wr(A_CTL, 32'h1);
    wr(A_CLO, 32'h0);
    wr(A_CTL, 32'h0);
    rd_cnt(v); chk("R4 write while running", v, after_ticks(s, 9));

    // R5, R9: exact deadline, single shot
    load_cnt(64'd0);
    wr(A_PLO, 32'd12); wr(A_PHI, 32'd0);
    wr(A_CTL, 32'h7);
    idle(12);
    chk("R5 no event before deadline", irq, 0);
    idle(1);
    chk("R5 event at deadline", irq, 1);
    wr(A_STA, 32'h1);
    chk("R8 clear", irq, 0);
    idle(5);
    rd(A_STA, d); chk("R6 no refire same comparator", d, 0);
    wr(A_CTL, 32'h0);

    // R8: event and clear in the same cycle, set wins
    load_cnt(64'd0);
    wr(A_PLO, 32'd6);
    wr(A_CTL, 32'h7);
    idle(6);
    wr(A_STA, 32'h1);
    chk("R8 set beats clear", irq, 1);
    wr(A_STA, 32'h1);
    chk("R8 clear afterwards", irq, 0);

    // R6: rewriting comparator re-arms
    wr(A_PLO, 32'd3);
    idle(1);
    chk("R6 rearm fires", irq, 1);
    wr(A_CTL, 32'h0);
    wr(A_STA, 32'h1);

    // R7, R9, R8: periodic reload
    load_cnt(64'd0);
    wr(A_PLO, 32'd20); wr(A_PHI, 32'd0);
    wr(A_STP, 32'd20);
    wr(A_CTL, 32'hF);
    idle(29);
    chk("R9 irq in periodic", irq, 1);
    wr(A_CTL, 32'h0);
    chk("R9 irq gated by enable", irq, 0);
    rd(A_PLO, d); chk("R7 comparator advanced", d, 40);
    rd(A_PHI, d); chk("R7 comparator high", d, 0);
    rd_cnt(v); chk("R7 count", v, 30);
    wr(A_CTL, 32'h4);
    chk("R9 irq on enable", irq, 1);
    wr(A_STA, 32'h0);
    rd(A_STA, d); chk("R8 write zero keeps flag", d, 1);
    wr(A_STA, 32'h1);
    rd(A_STA, d); chk("R8 write one clears", d, 0);
    chk("R9 irq low after clear", irq, 0);

    // R7: reload across the 64-bit carry of the comparator
    wr(A_CTL, 32'h0);
    load_cnt({32'd0, 32'hFFFF_FFF0});
    wr(A_PLO, 32'hFFFF_FFF0); wr(A_PHI, 32'd0);
    wr(A_STP, 32'h20);
    wr(A_CTL, 32'hB);
    idle(2);
    wr(A_CTL, 32'h0);
    rd(A_PLO, d); chk("R7 cmp wrap lo", d, 32'h10);
    rd(A_PHI, d); chk("R7 cmp wrap hi", d, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule